// File: doc/BRIEF.md
# Associative Maximum Finder

This block holds a small bank of unsigned words in a masked, equality-only associative array. On request it finds the largest stored value. It has no magnitude comparator. The sequencer opens one bit column at a time, from the most significant bit downward. At each step it clears the tag bits and runs an equality search under the current column mask. The collective response then decides one of two moves: open the next column, or drop the tentative 1 in the comparand for the newest column. When every column is open and a search still responds, the comparand holds the maximum. The run time therefore grows with the word width and does not depend on the word count.

Software-free use is intended. A neighbour writes words through the load port while the block is idle, then pulses `start`. When `done` pulses, it reads the maximum and a tag vector marking every word that holds that maximum.

Top module: `maxfind_top`

## Requirements
- R1: After reset `busy`, `done`, `max_value` and `match_tags` are all 0.
- R2: While idle, `load_en` writes `load_data` into word `load_addr` on the next clock edge. A load presented while `busy` is 1 is ignored and leaves the stored words unchanged.
- R3: A `start` pulse while idle makes `busy` 1 on the following cycle. A `start` pulse while busy is ignored and does not alter the result or the timing.
- R4: When `done` is 1, `max_value` equals the largest unsigned value among the stored words.
- R5: When `done` is 1, bit j of `match_tags` is 1 exactly when word j equals the maximum. This bit vector is never empty. `max_value` and `match_tags` hold until the next completed run.
- R6: `done` is high for exactly one cycle, and `busy` is 0 in that same cycle.
- R7: When every stored word is zero, the run still ends with `max_value` equal to 0 and all tag bits set.
- R8: The run uses S = 1 + WIDTH + Z equality searches, where Z is the number of 0 bits in the maximum. Each search costs two cycles, so `done` rises 2·S cycles after the edge that samples `start`. During a run the column mask only gains ones, and the comparand only loses ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write one word (idle only) |
| load_addr | input | $clog2(WORDS) | Word index to write |
| load_data | input | WIDTH | Value to write |
| start | input | 1 | Begin a maximum search |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| max_value | output | WIDTH | Largest stored value |
| match_tags | output | WORDS | Words equal to the maximum |

## Verification
A wrong column choice or comparand edit shows up directly as a wrong `max_value` at the `done` pulse. It also shifts the completion cycle, because the number of searches is fixed by the zero bits of the true maximum. Checking the exact cycle count therefore catches branch errors that happen to yield the right value. A stale or uncleared tag register appears as extra bits in `match_tags` in the same completion cycle. A load or start that leaks through during a run shows up as a changed result or timing on that run, or on the next run over unchanged data.

// File: rtl/maxfind_pkg.sv
package maxfind_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SRCH = 2'd1,
    ST_EVAL = 2'd2
  } seq_state_t;
endpackage

// File: rtl/maxfind_cam.sv
// Word storage with one parallel masked-equality comparator per word.
module maxfind_cam #(
  parameter int WORDS = 8,
  parameter int WIDTH = 8,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] key,
  input  logic [WIDTH-1:0] care,
  output logic [WORDS-1:0] hit
);
  logic [WIDTH-1:0] cells [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  for (genvar j = 0; j < WORDS; j++) begin : g_line
    assign hit[j] = ((cells[j] ^ key) & care) == '0;
  end
endmodule

// File: rtl/maxfind_colsel.sv
// Finds the leftmost closed column and the rightmost open column of the mask.
module maxfind_colsel #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] open_next,
  output logic [WIDTH-1:0] last_open,
  output logic             all_open
);
  always_comb begin
    open_next = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (!mask[i]) open_next = '0 | (WIDTH'(1) << i);
    end
  end

  always_comb begin
    last_open = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (mask[i]) last_open = '0 | (WIDTH'(1) << i);
    end
  end

  assign all_open = &mask;
endmodule

// File: rtl/maxfind_ctrl.sv
// Sequencer: clear tags, search, evaluate the response, adjust mask or comparand.
module maxfind_ctrl
  import maxfind_pkg::*;
#(
  parameter int WORDS = 8,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WORDS-1:0] hit,
  input  logic [WIDTH-1:0] open_next,
  input  logic [WIDTH-1:0] last_open,
  input  logic             all_open,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] comp,
  output logic [WIDTH-1:0] max_value,
  output logic [WORDS-1:0] match_tags
);
  seq_state_t       state;
  logic [WORDS-1:0] tags;
  logic             any_hit;

  assign any_hit = |tags;
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mask       <= '0;
      comp       <= '0;
      tags       <= '0;
      done       <= 1'b0;
      max_value  <= '0;
      match_tags <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            comp  <= '1;
            mask  <= '0;
            tags  <= '0;
            state <= ST_SRCH;
          end
        end
        ST_SRCH: begin
          tags  <= hit;
          state <= ST_EVAL;
        end
        ST_EVAL: begin
          if (any_hit) begin
            if (all_open) begin
              done       <= 1'b1;
              max_value  <= comp;
              match_tags <= tags;
              state      <= ST_IDLE;
            end else begin
              mask  <= mask | open_next;
              tags  <= '0;
              state <= ST_SRCH;
            end
          end else begin
            comp  <= comp & ~last_open;
            state <= ST_SRCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/maxfind_top.sv
module maxfind_top #(
  parameter int WORDS = 8,
  parameter int WIDTH = 8,
  localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [AW-1:0]    load_addr,
  input  logic [WIDTH-1:0] load_data,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] max_value,
  output logic [WORDS-1:0] match_tags
);
  logic [WIDTH-1:0] mask_w, comp_w, open_next_w, last_open_w;
  logic [WORDS-1:0] hit_w;
  logic             all_open_w;
  logic             wr_ok;

  assign wr_ok = load_en & ~busy;

  maxfind_cam #(.WORDS(WORDS), .WIDTH(WIDTH)) u_cam (
    .clk(clk), .wr_en(wr_ok), .wr_addr(load_addr), .wr_data(load_data),
    .key(comp_w), .care(mask_w), .hit(hit_w)
  );

  maxfind_colsel #(.WIDTH(WIDTH)) u_sel (
    .mask(mask_w), .open_next(open_next_w), .last_open(last_open_w),
    .all_open(all_open_w)
  );

  maxfind_ctrl #(.WORDS(WORDS), .WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .hit(hit_w),
    .open_next(open_next_w), .last_open(last_open_w), .all_open(all_open_w),
    .busy(busy), .done(done), .mask(mask_w), .comp(comp_w),
    .max_value(max_value), .match_tags(match_tags)
  );
endmodule

// File: rtl/maxfind_chk.sv
module maxfind_chk #(
  parameter int WORDS = 8,
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] max_value,
  input logic [WORDS-1:0] match_tags,
  input logic [WIDTH-1:0] mask,
  input logic [WIDTH-1:0] comp
);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  assert_tags_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (match_tags != '0));
  assert_result_comp_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (max_value == comp));
  assert_hold_value_R5: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(max_value) && $stable(match_tags)));
  assert_mask_grows_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($countones(mask) >= $countones($past(mask))));
  assert_comp_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ((comp & ~$past(comp)) == '0));
endmodule

bind maxfind_top maxfind_chk #(.WORDS(WORDS), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .max_value(max_value), .match_tags(match_tags), .mask(mask_w), .comp(comp_w)
);

// File: tb/tb_maxfind_top.sv
module tb_maxfind_top;
  localparam int K = 8;
  localparam int W = 8;
  localparam int AW = $clog2(K);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst = 1'b1;
  logic load_en = 1'b0, start = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [W-1:0]  load_data = '0;
  logic busy, done;
  logic [W-1:0] max_value;
  logic [K-1:0] match_tags;

  logic [W-1:0] model [K];
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  maxfind_top #(.WORDS(K), .WIDTH(W)) dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .start(start), .busy(busy), .done(done),
    .max_value(max_value), .match_tags(match_tags)
  );

  task automatic check(string req, string what, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_word(int idx, logic [W-1:0] v);
    @(negedge clk);
    load_en = 1'b1; load_addr = AW'(idx); load_data = v;
    @(negedge clk);
    load_en = 1'b0;
    model[idx] = v;
  endtask

  task automatic run_check(string name, bit poke_start, bit poke_load);
    logic [W-1:0] emax = '0;
    logic [K-1:0] etag = '0;
    int zeros = 0, elat, n;
    for (int j = 0; j < K; j++) if (model[j] > emax) emax = model[j];
    for (int j = 0; j < K; j++) etag[j] = (model[j] == emax);
    for (int b = 0; b < W; b++) if (!emax[b]) zeros++;
    elat = 2 * (1 + W + zeros) + 1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    check("R3", {name, " busy after start"}, busy, 1);
    while (!done && n < 1000) begin
      start = (poke_start && n == 3);
      load_en = (poke_load && n == 4);
      load_addr = '0;
      load_data = '1;
      @(negedge clk);
      n++;
    end
    start = 1'b0; load_en = 1'b0;
    check("R8", {name, " latency"}, n, elat);
    check("R4", {name, " max"}, max_value, emax);
    check("R5", {name, " tags"}, match_tags, etag);
    check("R6", {name, " busy at done"}, busy, 0);
    @(negedge clk);
    check("R6", {name, " done single"}, done, 0);
    check("R5", {name, " max held"}, max_value, emax);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "max", max_value, 0);
    check("R1", "tags", match_tags, 0);
  endtask

  task automatic t_zero();
    for (int j = 0; j < K; j++) load_word(j, '0);
    run_check("R7 zero", 0, 0);
    check("R7", "all tags", match_tags, {K{1'b1}});
  endtask

  task automatic t_distinct();
    for (int j = 0; j < K; j++) load_word(j, W'(j * 13 + 5));
    run_check("R2 distinct", 0, 0);
  endtask

  task automatic t_dups();
    for (int j = 0; j < K; j++) load_word(j, W'(8'h40 + j));
    load_word(1, 8'hA6);
    load_word(6, 8'hA6);
    run_check("R5 dups", 0, 0);
  endtask

  task automatic t_allones();
    for (int j = 0; j < K; j++) load_word(j, '1);
    run_check("R8 full", 0, 0);
  endtask

  task automatic t_single();
    for (int j = 0; j < K; j++) load_word(j, '0);
    load_word(K - 1, 8'h01);
    run_check("R4 single", 0, 0);
  endtask

  task automatic t_busy_pokes();
    for (int j = 0; j < K; j++) load_word(j, W'(8'h10 + 3 * j));
    run_check("R3 R2 pokes", 1, 1);
    run_check("R2 rerun", 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int j = 0; j < K; j++) model[j] = '0;
    t_reset();
    t_zero();
    t_distinct();
    t_dups();
    t_allones();
    t_single();
    t_busy_pokes();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule